// File: doc/BRIEF.md
# Wide Register Write Collector

This block sits on the host write path of a network interface and turns narrow host writes into whole 128-bit register updates. Each queue owns a page of registers; inside a page two wide descriptor-update registers (one for receive, one for transmit) span four dwords each, and four ordinary 32-bit registers are written straight through. The host issues naturally aligned 32-bit or 64-bit writes. Lower dwords of a wide register are gathered in one shared collector; the write that lands on the top dword fires a single-cycle commit carrying the page, the receive/transmit select and the full 128 bits.

The collector is a two-state machine. `ST_EMPTY` holds nothing; `ST_HOLD` holds one to three lower dwords tagged with their page and register. Transitions: T_START (`ST_EMPTY` to `ST_HOLD`, lower-dword write), T_MERGE (`ST_HOLD` to `ST_HOLD`, lower-dword write to the held page and register), T_RESTART (`ST_HOLD` to `ST_HOLD`, lower-dword write to another page or register, old data dropped), T_COMMIT (either state to `ST_EMPTY`, top-dword write) and T_INVAL (`ST_HOLD` to `ST_EMPTY`, timer-command write in page 0). Lower dwords that were never collected for the committing page and register go out as zero; the commit is never stalled.

Misaligned writes, 64-bit writes to dword registers and writes to offsets that decode to nothing are dropped and set a sticky error flag.

Top module: `wide_write_collector`

## Requirements
- R1: A wide register may be written as four 32-bit writes at +0, +4, +8, +12 or as two 64-bit writes at +0 and +8 (low half of the 64-bit data to the lower dword); dword i of the register lands in commit bits 32i+31:32i.
- R2: A write covering the top dword (+12) always commits, one clock after the write, as a one-cycle `commit_valid` pulse with `commit_page` and `commit_is_tx` (0 for the receive register at in-page offset 0x830, 1 for the transmit register at 0xA10); lower-dword writes alone never commit.
- R3: Lower dwords neither carried by the committing write nor collected for the same page and register are committed as zero.
- R4: After a commit the collector is empty, so a following top-only write commits zeros in bits 95:0.
- R5: A lower-dword write to a page or register other than the held one discards the held dwords and restarts collection with the new write.
- R6: The page index is the write address divided by the parameter STRIDE (a power of two, default 0x2000); the in-page offset is the remainder.
- R7: 32-bit writes to in-page offsets 0x180, 0x200, 0x400, 0x420 produce a one-cycle `dw_valid` pulse one clock later with `dw_sel` 0, 1, 2, 3 respectively, the page and the data, and never a commit; except as in R8 they leave the collector intact.
- R8: A 32-bit write to offset 0x420 in page 0 empties the collector; the same offset in any other page does not.
- R9: A misaligned write (32-bit with address bits 1:0 nonzero, 64-bit with bits 2:0 nonzero), a 64-bit write to a dword register, or a write to an undecoded offset produces no pulse, leaves the collector intact and sets `err_flag`, which stays set until reset.
- R10: Out of reset no pulse is output, `err_flag` is 0 and the collector is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_is64 | input | 1 | 1 for a 64-bit write, 0 for 32-bit |
| wr_data | input | 64 | Write data; bits 31:0 used by 32-bit writes |
| commit_valid | output | 1 | One-cycle wide register commit |
| commit_page | output | PAGE_W | Page of the committed register |
| commit_is_tx | output | 1 | 0 receive register, 1 transmit register |
| commit_data | output | 128 | Full committed value |
| dw_valid | output | 1 | One-cycle direct dword write |
| dw_page | output | PAGE_W | Page of the direct write |
| dw_sel | output | 2 | Which direct register (0x180, 0x200, 0x400, 0x420) |
| dw_data | output | 32 | Direct write data |
| err_flag | output | 1 | Sticky bad-write flag |

## Verification
The assertions assume a host that presents at most one write per cycle with a known address and size whenever `wr_valid` is high, and that nothing else drives the collector; the bench drives each write for exactly one cycle between falling edges and leaves `wr_valid` low between writes, so every pulse is traceable to one write. Under that assumption the checks rely on the commit and direct pulses never coinciding, on the collector being empty whenever it is idle or has just committed, and on the error flag never falling outside reset. The stimulus walks every transition of the collector, both wide registers, all four direct registers, page 0 against other pages, the highest page and each class of bad write.

// File: rtl/wwc_pkg.sv
package wwc_pkg;
    localparam int DWORD_W = 32;
    localparam int NUM_DW  = 4;
    localparam int LOW_DW  = NUM_DW - 1;

    typedef enum logic [1:0] {
        WK_BAD,
        WK_WIDE,
        WK_DIRECT
    } wkind_t;

    typedef enum logic {
        ST_EMPTY,
        ST_HOLD
    } cstate_t;

    localparam int OFS_RX_WIDE = 32'h830;
    localparam int OFS_TX_WIDE = 32'hA10;
    localparam int OFS_DIR0    = 32'h180;
    localparam int OFS_DIR1    = 32'h200;
    localparam int OFS_DIR2    = 32'h400;
    localparam int OFS_TIMER   = 32'h420;
endpackage

// File: rtl/wwc_decode.sv
module wwc_decode
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int STRIDE = 32'h2000,
    localparam int OFS_W  = $clog2(STRIDE),
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            is64,
    input  logic [63:0]                     data,
    output wkind_t                          kind,
    output logic [PAGE_W-1:0]               page,
    output logic                            is_tx,
    output logic [1:0]                      dsel,
    output logic [NUM_DW-1:0]               sup,
    output logic [NUM_DW-1:0][DWORD_W-1:0]  lanes,
    output logic                            timer0
);
    localparam logic [OFS_W-1:0] RX_BASE = OFS_W'(OFS_RX_WIDE);
    localparam logic [OFS_W-1:0] TX_BASE = OFS_W'(OFS_TX_WIDE);

    logic [OFS_W-1:0] ofs;
    logic [1:0]       idx;
    logic             aligned;
    logic             in_rx;
    logic             in_tx;
    logic             dir_hit;

    always_comb begin
        ofs     = addr[OFS_W-1:0];
        page    = addr[ADDR_W-1:OFS_W];
        idx     = ofs[3:2];
        aligned = is64 ? (addr[2:0] == 3'b000) : (addr[1:0] == 2'b00);
        in_rx   = (ofs[OFS_W-1:4] == RX_BASE[OFS_W-1:4]);
        in_tx   = (ofs[OFS_W-1:4] == TX_BASE[OFS_W-1:4]);
        is_tx   = in_tx;

        dir_hit = 1'b1;
        dsel    = 2'd0;
        if (ofs == OFS_W'(OFS_DIR0))       dsel = 2'd0;
        else if (ofs == OFS_W'(OFS_DIR1))  dsel = 2'd1;
        else if (ofs == OFS_W'(OFS_DIR2))  dsel = 2'd2;
        else if (ofs == OFS_W'(OFS_TIMER)) dsel = 2'd3;
        else                               dir_hit = 1'b0;

        kind = WK_BAD;
        sup  = '0;
        if (aligned) begin
            if (in_rx || in_tx) begin
                kind = WK_WIDE;
                if (is64) sup = idx[1] ? 4'b1100 : 4'b0011;
                else      sup = 4'b0001 << idx;
            end else if (dir_hit && !is64) begin
                kind = WK_DIRECT;
            end
        end

        for (int i = 0; i < NUM_DW; i++) begin
            if (is64 && (i % 2 == 1)) lanes[i] = data[63:32];
            else                      lanes[i] = data[31:0];
        end

        timer0 = (kind == WK_DIRECT) && (dsel == 2'd3) && (page == '0);
    end
endmodule

// File: rtl/wwc_collector.sv
module wwc_collector
    import wwc_pkg::*;
#(
    parameter int PAGE_W = 11
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wide_we,
    input  logic                            inval,
    input  logic [PAGE_W-1:0]               page,
    input  logic                            is_tx,
    input  logic [NUM_DW-1:0]               sup,
    input  logic [NUM_DW-1:0][DWORD_W-1:0]  lanes,
    output logic                            commit_valid,
    output logic [PAGE_W-1:0]               commit_page,
    output logic                            commit_is_tx,
    output logic [NUM_DW*DWORD_W-1:0]       commit_data,
    output logic [LOW_DW-1:0]               mask_o,
    output logic                            busy_o
);
    cstate_t                            state, state_n;
    logic [LOW_DW-1:0]                  mask, mask_n;
    logic [PAGE_W-1:0]                  h_page, h_page_n;
    logic                               h_tx, h_tx_n;
    logic [LOW_DW-1:0][DWORD_W-1:0]     h_data, h_data_n;
    logic [NUM_DW-1:0][DWORD_W-1:0]     asm_w;
    logic                               same;
    logic                               commit_now;

    always_comb begin
        same       = (state == ST_HOLD) && (h_page == page) && (h_tx == is_tx);
        commit_now = wide_we && sup[NUM_DW-1];

        for (int i = 0; i < LOW_DW; i++) begin
            if (sup[i])                 asm_w[i] = lanes[i];
            else if (same && mask[i])   asm_w[i] = h_data[i];
            else                        asm_w[i] = '0;
        end
        asm_w[NUM_DW-1] = lanes[NUM_DW-1];

        state_n  = state;
        mask_n   = mask;
        h_page_n = h_page;
        h_tx_n   = h_tx;
        h_data_n = h_data;
        for (int i = 0; i < LOW_DW; i++)
            if (wide_we && sup[i]) h_data_n[i] = lanes[i];

        unique case (state)
            ST_EMPTY: begin
                if (commit_now) begin
                    state_n = ST_EMPTY;                // T_COMMIT
                    mask_n  = '0;
                end else if (wide_we) begin
                    state_n  = ST_HOLD;                // T_START
                    mask_n   = sup[LOW_DW-1:0];
                    h_page_n = page;
                    h_tx_n   = is_tx;
                end
            end
            ST_HOLD: begin
                if (commit_now) begin
                    state_n = ST_EMPTY;                // T_COMMIT
                    mask_n  = '0;
                end else if (wide_we && same) begin
                    mask_n = mask | sup[LOW_DW-1:0];   // T_MERGE
                end else if (wide_we) begin
                    mask_n   = sup[LOW_DW-1:0];        // T_RESTART
                    h_page_n = page;
                    h_tx_n   = is_tx;
                end else if (inval) begin
                    state_n = ST_EMPTY;                // T_INVAL
                    mask_n  = '0;
                end
            end
            default: begin
                state_n = ST_EMPTY;
                mask_n  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_EMPTY;
            mask   <= '0;
            h_page <= '0;
            h_tx   <= 1'b0;
            h_data <= '0;
        end else begin
            state  <= state_n;
            mask   <= mask_n;
            h_page <= h_page_n;
            h_tx   <= h_tx_n;
            h_data <= h_data_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_valid <= 1'b0;
            commit_page  <= '0;
            commit_is_tx <= 1'b0;
            commit_data  <= '0;
        end else begin
            commit_valid <= commit_now;
            if (commit_now) begin
                commit_page  <= page;
                commit_is_tx <= is_tx;
                commit_data  <= asm_w;
            end
        end
    end

    assign mask_o = mask;
    assign busy_o = (state == ST_HOLD);
endmodule

// File: rtl/wide_write_collector.sv
module wide_write_collector
    import wwc_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int STRIDE = 32'h2000,
    localparam int OFS_W  = $clog2(STRIDE),
    localparam int PAGE_W = ADDR_W - OFS_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_valid,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic                          wr_is64,
    input  logic [63:0]                   wr_data,
    output logic                          commit_valid,
    output logic [PAGE_W-1:0]             commit_page,
    output logic                          commit_is_tx,
    output logic [NUM_DW*DWORD_W-1:0]     commit_data,
    output logic                          dw_valid,
    output logic [PAGE_W-1:0]             dw_page,
    output logic [1:0]                    dw_sel,
    output logic [DWORD_W-1:0]            dw_data,
    output logic                          err_flag
);
    wkind_t                            d_kind;
    logic [PAGE_W-1:0]                 d_page;
    logic                              d_tx;
    logic [1:0]                        d_sel;
    logic [NUM_DW-1:0]                 d_sup;
    logic [NUM_DW-1:0][DWORD_W-1:0]    d_lanes;
    logic                              d_timer0;
    logic [LOW_DW-1:0]                 coll_mask;
    logic                              coll_busy;

    wwc_decode #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_dec (
        .addr   (wr_addr),
        .is64   (wr_is64),
        .data   (wr_data),
        .kind   (d_kind),
        .page   (d_page),
        .is_tx  (d_tx),
        .dsel   (d_sel),
        .sup    (d_sup),
        .lanes  (d_lanes),
        .timer0 (d_timer0)
    );

    wwc_collector #(.PAGE_W(PAGE_W)) u_coll (
        .clk          (clk),
        .rst_n        (rst_n),
        .wide_we      (wr_valid && (d_kind == WK_WIDE)),
        .inval        (wr_valid && d_timer0),
        .page         (d_page),
        .is_tx        (d_tx),
        .sup          (d_sup),
        .lanes        (d_lanes),
        .commit_valid (commit_valid),
        .commit_page  (commit_page),
        .commit_is_tx (commit_is_tx),
        .commit_data  (commit_data),
        .mask_o       (coll_mask),
        .busy_o       (coll_busy)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dw_valid <= 1'b0;
            dw_page  <= '0;
            dw_sel   <= '0;
            dw_data  <= '0;
            err_flag <= 1'b0;
        end else begin
            dw_valid <= wr_valid && (d_kind == WK_DIRECT);
            if (wr_valid && (d_kind == WK_DIRECT)) begin
                dw_page <= d_page;
                dw_sel  <= d_sel;
                dw_data <= wr_data[DWORD_W-1:0];
            end
            if (wr_valid && (d_kind == WK_BAD)) err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/wwc_checker.sv
module wwc_checker #(
    parameter int ADDR_W = 24,
    parameter int LOW_DW = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              wr_is64,
    input logic              commit_valid,
    input logic              dw_valid,
    input logic              err_flag,
    input logic [LOW_DW-1:0] coll_mask,
    input logic              coll_busy
);
    a_r9_input_known: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !$isunknown({wr_addr, wr_is64}));

    a_r2_commit_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> $past(wr_valid));

    a_r7_direct_from_write: assert property (@(posedge clk) disable iff (!rst_n)
        dw_valid |-> $past(wr_valid));

    a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(dw_valid && commit_valid));

    a_r4_empty_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (!coll_busy && coll_mask == '0));

    a_r10_idle_mask_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !coll_busy |-> (coll_mask == '0));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

bind wide_write_collector wwc_checker #(.ADDR_W(ADDR_W), .LOW_DW(wwc_pkg::LOW_DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .wr_addr      (wr_addr),
    .wr_is64      (wr_is64),
    .commit_valid (commit_valid),
    .dw_valid     (dw_valid),
    .err_flag     (err_flag),
    .coll_mask    (coll_mask),
    .coll_busy    (coll_busy)
);

// File: tb/wide_write_collector_bench.sv
module wide_write_collector_bench;
    localparam int ADDR_W = 24;
    localparam int STRIDE = 32'h2000;
    localparam int PAGE_W = ADDR_W - $clog2(STRIDE);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_valid = 1'b0;
    logic [ADDR_W-1:0]  wr_addr = '0;
    logic               wr_is64 = 1'b0;
    logic [63:0]        wr_data = '0;
    logic               commit_valid;
    logic [PAGE_W-1:0]  commit_page;
    logic               commit_is_tx;
    logic [127:0]       commit_data;
    logic               dw_valid;
    logic [PAGE_W-1:0]  dw_page;
    logic [1:0]         dw_sel;
    logic [31:0]        dw_data;
    logic               err_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    wide_write_collector #(.ADDR_W(ADDR_W), .STRIDE(STRIDE)) u_wide_write_collector (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_is64(wr_is64), .wr_data(wr_data), .commit_valid(commit_valid),
        .commit_page(commit_page), .commit_is_tx(commit_is_tx),
        .commit_data(commit_data), .dw_valid(dw_valid), .dw_page(dw_page),
        .dw_sel(dw_sel), .dw_data(dw_data), .err_flag(err_flag)
    );

    localparam int RXO = 32'h830;
    localparam int TXO = 32'hA10;

    function automatic logic [ADDR_W-1:0] pa(input int page, input int ofs);
        return ADDR_W'(page * STRIDE + ofs);
    endfunction

    task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // One write held for one cycle; on return the registered outputs reflect it.
    task automatic wr(input logic [ADDR_W-1:0] a, input logic w64, input logic [63:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_is64 = w64; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic expect_commit(input string req, input int page, input logic tx, input logic [127:0] d);
        chk(req, "commit_valid", 128'(commit_valid), 128'(1'b1));
        chk(req, "commit_page", 128'(commit_page), 128'(page));
        chk(req, "commit_is_tx", 128'(commit_is_tx), 128'(tx));
        chk(req, "commit_data", commit_data, d);
    endtask

    task automatic expect_quiet(input string req);
        chk(req, "commit_valid", 128'(commit_valid), 128'(1'b0));
        chk(req, "dw_valid", 128'(dw_valid), 128'(1'b0));
    endtask

    task automatic t_reset;
        expect_quiet("R10");
        chk("R10", "err_flag", 128'(err_flag), 128'(1'b0));
        wr(pa(0, RXO + 12), 1'b0, 64'h1111_0000);
        expect_commit("R10", 0, 1'b0, {32'h1111_0000, 96'h0});
    endtask

    task automatic t_four32;
        wr(pa(3, RXO + 0), 1'b0, 64'hA0);
        expect_quiet("R2");
        wr(pa(3, RXO + 4), 1'b0, 64'hA1);
        wr(pa(3, RXO + 8), 1'b0, 64'hA2);
        expect_quiet("R2");
        wr(pa(3, RXO + 12), 1'b0, 64'hA3);
        expect_commit("R1", 3, 1'b0, {32'hA3, 32'hA2, 32'hA1, 32'hA0});
        @(negedge clk);
        chk("R2", "pulse one cycle", 128'(commit_valid), 128'(1'b0));
    endtask

    task automatic t_two64;
        wr(pa(5, TXO + 0), 1'b1, 64'hB1_0000_00B0);
        expect_quiet("R1");
        wr(pa(5, TXO + 8), 1'b1, 64'hB3_0000_00B2);
        expect_commit("R1", 5, 1'b1, {32'hB3, 32'hB2, 32'hB1, 32'hB0});
    endtask

    task automatic t_after_commit;
        wr(pa(5, TXO + 12), 1'b0, 64'hC3);
        expect_commit("R4", 5, 1'b1, {32'hC3, 96'h0});
    endtask

    task automatic t_partial;
        wr(pa(2, RXO + 4), 1'b0, 64'hD1);
        wr(pa(2, RXO + 12), 1'b0, 64'hD3);
        expect_commit("R3", 2, 1'b0, {32'hD3, 32'h0, 32'hD1, 32'h0});
        wr(pa(4, TXO + 0), 1'b0, 64'hD0);
        wr(pa(6, TXO + 12), 1'b0, 64'hD3);
        expect_commit("R3", 6, 1'b1, {32'hD3, 96'h0});
    endtask

    task automatic t_switch;
        wr(pa(1, RXO + 0), 1'b0, 64'hE0);
        wr(pa(2, RXO + 4), 1'b0, 64'hE1);
        wr(pa(2, RXO + 12), 1'b0, 64'hE3);
        expect_commit("R5", 2, 1'b0, {32'hE3, 32'h0, 32'hE1, 32'h0});
        wr(pa(1, RXO + 8), 1'b0, 64'hF2);
        wr(pa(1, TXO + 0), 1'b0, 64'hF0);
        wr(pa(1, RXO + 12), 1'b0, 64'hF3);
        expect_commit("R5", 1, 1'b0, {32'hF3, 96'h0});
    endtask

    task automatic t_direct;
        wr(pa(0, RXO + 0), 1'b0, 64'h77);
        wr(pa(7, 32'h180), 1'b0, 64'h5180);
        chk("R7", "dw_valid", 128'(dw_valid), 128'(1'b1));
        chk("R7", "dw_sel", 128'(dw_sel), 128'(2'd0));
        chk("R7", "dw_page", 128'(dw_page), 128'(7));
        chk("R7", "dw_data", 128'(dw_data), 128'(32'h5180));
        chk("R7", "no commit", 128'(commit_valid), 128'(1'b0));
        wr(pa(7, 32'h200), 1'b0, 64'h5200);
        chk("R7", "dw_sel", 128'(dw_sel), 128'(2'd1));
        wr(pa(0, 32'h400), 1'b0, 64'h5400);
        chk("R7", "dw_sel", 128'(dw_sel), 128'(2'd2));
        chk("R7", "dw_data", 128'(dw_data), 128'(32'h5400));
        wr(pa(0, RXO + 12), 1'b0, 64'h7F);
        expect_commit("R7", 0, 1'b0, {32'h7F, 64'h0, 32'h77});
    endtask

    task automatic t_timer;
        wr(pa(0, RXO + 4), 1'b0, 64'h91);
        wr(pa(0, 32'h420), 1'b0, 64'h9420);
        chk("R8", "dw_sel", 128'(dw_sel), 128'(2'd3));
        chk("R8", "dw_valid", 128'(dw_valid), 128'(1'b1));
        wr(pa(0, RXO + 12), 1'b0, 64'h93);
        expect_commit("R8", 0, 1'b0, {32'h93, 96'h0});
        wr(pa(1, TXO + 4), 1'b0, 64'h81);
        wr(pa(1, 32'h420), 1'b0, 64'h8420);
        chk("R8", "dw_page", 128'(dw_page), 128'(1));
        wr(pa(1, TXO + 12), 1'b0, 64'h83);
        expect_commit("R8", 1, 1'b1, {32'h83, 32'h0, 32'h81, 32'h0});
    endtask

    task automatic t_errors;
        wr(pa(3, TXO + 0), 1'b0, 64'h60);
        wr(pa(3, TXO + 4), 1'b1, 64'hDEAD_BEEF);
        expect_quiet("R9");
        chk("R9", "err_flag", 128'(err_flag), 128'(1'b1));
        wr(pa(3, 32'h100), 1'b0, 64'hBAD);
        expect_quiet("R9");
        wr(pa(3, 32'h180), 1'b1, 64'hBAD);
        expect_quiet("R9");
        wr(pa(3, TXO + 6), 1'b0, 64'hBAD);
        expect_quiet("R9");
        wr(pa(3, TXO + 12), 1'b0, 64'h63);
        expect_commit("R9", 3, 1'b1, {32'h63, 64'h0, 32'h60});
        chk("R9", "err_flag held", 128'(err_flag), 128'(1'b1));
    endtask

    task automatic t_high_page;
        wr(pa(2047, TXO + 8), 1'b1, 64'h4444_0000_3333);
        expect_commit("R6", 2047, 1'b1, {32'h4444, 32'h3333, 64'h0});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_four32();
        t_two64();
        t_after_commit();
        t_partial();
        t_switch();
        t_direct();
        t_timer();
        t_errors();
        t_high_page();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule